// File: doc/BRIEF.md
# Double to Int32 Truncating Converter

This unit turns a 64-bit IEEE-754 double into a signed 32-bit integer. It always rounds toward zero, so the fractional part is dropped whatever the sign. Inputs that fall outside the integer range saturate to the nearest end of the range. Every NaN gives the most negative integer. The 32-bit result is copied into both halves of a 64-bit output word, so a consumer can pick up either half.

Operands come in on a valid/ready stream, and results with their status flags leave on a second valid/ready stream. The unit holds one result register. An input is taken on a clock edge where `in_valid` and `in_ready` are both high, and its result is presented on the next cycle. `in_ready` is high when the result register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and its flags stay frozen and no new operand is taken. There are four flags: inexact, invalid conversion, signaling NaN, and a rounded flag that this conversion never sets.

Top module: `dbl_to_i32_trunc`

## Requirements
- R1: While `out_valid` is high, `out_data[63:32]` equals `out_data[31:0]`, and both hold the converted integer.
- R2: A finite input whose value lies strictly between -2^31 and 2^31-1 gives its integer part, truncated toward zero for both signs. Inexact is set exactly when a nonzero fraction was dropped. Zeros of either sign give 0 with no flags. Subnormals, and any nonzero value with magnitude below 1, give 0 with inexact set.
- R3: An input exactly equal to -2^31 or to 2^31-1 gives that value with inexact and invalid clear.
- R4: An input strictly between 2^31-1 and 2^31 gives 2^31-1 with inexact set and invalid clear. An input strictly between -2^31-1 and -2^31 gives -2^31 with inexact set and invalid clear.
- R5: A positive input at or above 2^31, including +infinity, gives 2^31-1 (0x7FFFFFFF) with invalid set and inexact clear.
- R6: A negative input at or below -2^31-1, including -infinity, gives -2^31 (0x80000000) with invalid set and inexact clear.
- R7: A quiet NaN (exponent all ones, fraction bit 51 set) gives 0x80000000 with invalid set, signaling-NaN clear and inexact clear.
- R8: A signaling NaN (exponent all ones, fraction bit 51 clear, fraction nonzero) gives 0x80000000 with both invalid and signaling-NaN set.
- R9: The rounded flag is 0 on every result.
- R10: A result is presented on the cycle after its operand is accepted. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. Under back-pressure the result and flags stay stable. Results leave in acceptance order.
- R11: During and directly after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_data | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Integer result, replicated in both halves |
| out_flag_rounded | output | 1 | Rounded flag, always 0 |
| out_flag_inexact | output | 1 | A nonzero fraction was discarded |
| out_flag_invalid | output | 1 | NaN or out-of-range operand |
| out_flag_snan | output | 1 | Operand was a signaling NaN |

## Verification
The bench targets the thresholds one half-unit around each end of the integer range. A design that compares against the wrong bound would flag these as invalid when they should be inexact, or the reverse. It drives exactly -2^31 and -2^31-1 with exponent 31, where a sign-blind saturation rule would wrongly reject -2^31. It drives subnormals, ±0.5 and signed zeros, where a design that ignored the subnormal class or the exponent underflow would return garbage or a wrong inexact flag. Quiet and signaling NaNs of both signs check the quiet-bit decode. A randomized sweep of exponents across the whole range is compared against a real-number model, and a held-back consumer checks that a result does not change under stall.

// File: rtl/dti_pkg.sv
package dti_pkg;

  // Operand classes after field decode
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } dti_class_e;

  typedef struct packed {
    logic rounded;
    logic inexact;
    logic invalid;
    logic snan;
  } dti_flags_t;

endpackage

// File: rtl/dti_classify.sv
module dti_classify #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0]     op,
  output logic                     sign,
  output dti_pkg::dti_class_e      cls,
  output logic signed [EXP_W:0]    exp_unb,
  output logic [MAN_W-1:0]         frac
);
  import dti_pkg::*;

  localparam logic signed [EXP_W:0] BIAS = (EXP_W+1)'((1 << (EXP_W-1)) - 1);

  logic [EXP_W-1:0] exp_f;
  logic             exp_max;
  logic             exp_min;
  logic             frac_nz;

  assign sign    = op[EXP_W+MAN_W];
  assign exp_f   = op[EXP_W+MAN_W-1:MAN_W];
  assign frac    = op[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac;
  assign exp_unb = $signed({1'b0, exp_f}) - BIAS;

  always_comb begin
    if (exp_max) begin
      if (!frac_nz)            cls = CLS_INF;
      else if (frac[MAN_W-1])  cls = CLS_QNAN;
      else                     cls = CLS_SNAN;
    end else if (exp_min) begin
      cls = frac_nz ? CLS_SUB : CLS_ZERO;
    end else begin
      cls = CLS_NORM;
    end
  end

endmodule

// File: rtl/dti_truncate.sv
module dti_truncate #(
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  localparam int SH_W  = $clog2(INT_W),
  localparam int RSH_W = $clog2(MAN_W + 1)
) (
  input  logic [MAN_W-1:0] frac,
  input  logic [SH_W-1:0]  shamt,   // unbiased exponent, 0..INT_W-1
  output logic [INT_W-1:0] mag,
  output logic             lost
);

  logic [MAN_W:0]   mant;
  logic [RSH_W-1:0] rsh;
  logic [MAN_W-1:0] below_point;

  assign mant = {1'b1, frac};
  assign rsh  = RSH_W'(MAN_W) - RSH_W'(shamt);
  assign mag  = INT_W'(mant >> rsh);

  // fraction bits that fall below the binary point move to the top
  assign below_point = frac << shamt;
  assign lost        = |below_point;

endmodule

// File: rtl/dti_saturate.sv
module dti_saturate #(
  parameter int EXP_W = 11,
  parameter int INT_W = 32
) (
  input  dti_pkg::dti_class_e   cls,
  input  logic                  sign,
  input  logic signed [EXP_W:0] exp_unb,
  input  logic [INT_W-1:0]      mag,
  input  logic                  lost,
  output logic [INT_W-1:0]      result,
  output dti_pkg::dti_flags_t   flags
);
  import dti_pkg::*;

  localparam logic [INT_W-1:0]      NMAX  = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0]      NMIN  = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic signed [EXP_W:0] TOP_E = (EXP_W+1)'(INT_W - 1);

  always_comb begin
    result = '0;
    flags  = '0;
    unique case (cls)
      CLS_ZERO: ;
      CLS_SUB:  flags.inexact = 1'b1;
      CLS_INF: begin
        result        = sign ? NMIN : NMAX;
        flags.invalid = 1'b1;
      end
      CLS_QNAN: begin
        result        = NMIN;
        flags.invalid = 1'b1;
      end
      CLS_SNAN: begin
        result        = NMIN;
        flags.invalid = 1'b1;
        flags.snan    = 1'b1;
      end
      default: begin
        if (exp_unb[EXP_W]) begin
          flags.inexact = 1'b1;
        end else if (exp_unb > TOP_E) begin
          result        = sign ? NMIN : NMAX;
          flags.invalid = 1'b1;
        end else if (exp_unb == TOP_E) begin
          if (sign && (mag == NMIN)) begin
            result        = NMIN;
            flags.inexact = lost;
          end else begin
            result        = sign ? NMIN : NMAX;
            flags.invalid = 1'b1;
          end
        end else begin
          result        = sign ? (~mag + 1'b1) : mag;
          flags.inexact = lost;
        end
      end
    endcase
  end

endmodule

// File: rtl/dti_out_stage.sv
module dti_out_stage #(
  parameter int INT_W = 32,
  parameter int LANES = 2,
  localparam int OUT_W = INT_W * LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_valid,
  output logic                up_ready,
  input  logic [INT_W-1:0]    up_result,
  input  dti_pkg::dti_flags_t up_flags,
  output logic                dn_valid,
  input  logic                dn_ready,
  output logic [OUT_W-1:0]    dn_data,
  output dti_pkg::dti_flags_t dn_flags
);

  logic load;

  assign up_ready = !dn_valid || dn_ready;
  assign load     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        dn_valid <= 1'b0;
    else if (load)     dn_valid <= 1'b1;
    else if (dn_ready) dn_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    dn_flags <= '0;
    else if (load) dn_flags <= up_flags;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)    dn_data[g*INT_W +: INT_W] <= '0;
      else if (load) dn_data[g*INT_W +: INT_W] <= up_result;
    end
  end

endmodule

// File: rtl/dbl_to_i32_trunc.sv
module dbl_to_i32_trunc #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  parameter int LANES = 2,
  localparam int DBL_W = 1 + EXP_W + MAN_W,
  localparam int OUT_W = INT_W * LANES,
  localparam int SH_W  = $clog2(INT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DBL_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_flag_rounded,
  output logic             out_flag_inexact,
  output logic             out_flag_invalid,
  output logic             out_flag_snan
);
  import dti_pkg::*;

  logic                  sign;
  dti_class_e            cls;
  logic signed [EXP_W:0] exp_unb;
  logic [MAN_W-1:0]      frac;
  logic [INT_W-1:0]      mag;
  logic                  lost;
  logic [INT_W-1:0]      result;
  dti_flags_t            flags_c;
  dti_flags_t            flags_q;

  dti_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
    .op      (in_data),
    .sign    (sign),
    .cls     (cls),
    .exp_unb (exp_unb),
    .frac    (frac)
  );

  dti_truncate #(.MAN_W(MAN_W), .INT_W(INT_W)) u_truncate (
    .frac  (frac),
    .shamt (exp_unb[SH_W-1:0]),
    .mag   (mag),
    .lost  (lost)
  );

  dti_saturate #(.EXP_W(EXP_W), .INT_W(INT_W)) u_saturate (
    .cls     (cls),
    .sign    (sign),
    .exp_unb (exp_unb),
    .mag     (mag),
    .lost    (lost),
    .result  (result),
    .flags   (flags_c)
  );

  dti_out_stage #(.INT_W(INT_W), .LANES(LANES)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_valid  (in_valid),
    .up_ready  (in_ready),
    .up_result (result),
    .up_flags  (flags_c),
    .dn_valid  (out_valid),
    .dn_ready  (out_ready),
    .dn_data   (out_data),
    .dn_flags  (flags_q)
  );

  assign out_flag_rounded = flags_q.rounded;
  assign out_flag_inexact = flags_q.inexact;
  assign out_flag_invalid = flags_q.invalid;
  assign out_flag_snan    = flags_q.snan;

endmodule

// File: rtl/dti_checker.sv
module dti_checker #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  parameter int LANES = 2,
  localparam int DBL_W = 1 + EXP_W + MAN_W,
  localparam int OUT_W = INT_W * LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [DBL_W-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_flag_inexact,
  input logic             out_flag_invalid,
  input logic             out_flag_snan
);

  localparam logic [INT_W-1:0] NMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NMIN = {1'b1, {(INT_W-1){1'b0}}};

  logic take;
  logic in_nan;
  logic in_zero;

  assign take    = in_valid && in_ready;
  assign in_nan  = (&in_data[DBL_W-2:MAN_W]) && (|in_data[MAN_W-1:0]);
  assign in_zero = ~|in_data[DBL_W-2:0];

  AST_HALVES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[OUT_W-1 -: INT_W] == out_data[INT_W-1:0])); // R1

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_zero |=> out_valid && (out_data == '0) && !out_flag_inexact
                        && !out_flag_invalid); // R2

  AST_INVALID_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_invalid |-> !out_flag_inexact); // R5

  AST_INVALID_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_invalid |->
      (out_data[INT_W-1:0] == NMIN) || (out_data[INT_W-1:0] == NMAX)); // R6

  AST_NAN_TO_NMIN: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_nan |=> out_valid && (out_data[INT_W-1:0] == NMIN)
                       && out_flag_invalid); // R7

  AST_SNAN_IS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_snan |-> out_flag_invalid); // R8

  AST_ACCEPT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R10

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready)); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_flag_inexact) && $stable(out_flag_invalid)
      && $stable(out_flag_snan)); // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R11

endmodule

bind dbl_to_i32_trunc dti_checker #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .LANES(LANES)
) u_dti_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_valid         (in_valid),
  .in_ready         (in_ready),
  .in_data          (in_data),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_data         (out_data),
  .out_flag_inexact (out_flag_inexact),
  .out_flag_invalid (out_flag_invalid),
  .out_flag_snan    (out_flag_snan)
);

// File: tb/test_dbl_to_i32_trunc.sv
module test_dbl_to_i32_trunc;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NMAX = 32'h7FFF_FFFF;
  localparam logic [31:0] NMIN = 32'h8000_0000;

  // expected flag order: {rounded, inexact, invalid, snan}
  localparam logic [3:0] F_NONE = 4'b0000;
  localparam logic [3:0] F_INX  = 4'b0100;
  localparam logic [3:0] F_INV  = 4'b0010;
  localparam logic [3:0] F_SNAN = 4'b0011;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  flg;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic        out_flag_rounded;
  logic        out_flag_inexact;
  logic        out_flag_invalid;
  logic        out_flag_snan;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    hold_low = 1'b0;
  bit    done = 1'b0;
  int    rdy_cnt = 0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl_to_i32_trunc i_dbl_to_i32_trunc (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_valid         (in_valid),
    .in_ready         (in_ready),
    .in_data          (in_data),
    .out_valid        (out_valid),
    .out_ready        (out_ready),
    .out_data         (out_data),
    .out_flag_rounded (out_flag_rounded),
    .out_flag_inexact (out_flag_inexact),
    .out_flag_invalid (out_flag_invalid),
    .out_flag_snan    (out_flag_snan)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // consumer readiness changes just after a rising edge
  always @(posedge clk) begin
    #1;
    rdy_cnt++;
    out_ready <= hold_low ? 1'b0 : ((rdy_cnt % 5) != 3);
  end

  // monitor: a transfer is visible at the falling edge before it happens
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected result", out_data, '0);
      end else begin
        item_t it;
        logic [3:0] got_f;
        it = sb_q.pop_front();
        got_f = {out_flag_rounded, out_flag_inexact, out_flag_invalid, out_flag_snan};
        check(out_data == {it.res, it.res}, {it.tag, " R1 data"}, out_data, {it.res, it.res});
        check(got_f == it.flg, {it.tag, " flags"}, {60'd0, got_f}, {60'd0, it.flg});
      end
    end
  end

  task automatic send(input logic [63:0] d, input logic [31:0] r,
                      input logic [3:0] f, input string tag);
    item_t it;
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    it.res = r; it.flg = f; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic void model(input logic [63:0] d, output logic [31:0] r,
                                output logic [3:0] f);
    real x;
    int  i;
    if ((&d[62:52]) && (|d[51:0])) begin
      r = NMIN;
      f = d[51] ? F_INV : F_SNAN;
    end else begin
      x = $bitstoreal(d);
      if (x >= 2147483648.0) begin
        r = NMAX; f = F_INV;
      end else if (x <= -2147483649.0) begin
        r = NMIN; f = F_INV;
      end else begin
        i = $rtoi(x);
        r = i;
        f = ($itor(i) != x) ? F_INX : F_NONE;
      end
    end
  endfunction

  task automatic send_model(input logic [63:0] d, input string tag);
    logic [31:0] r;
    logic [3:0]  f;
    model(d, r, f);
    send(d, r, f, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R11 out_valid in reset", {63'd0, out_valid}, '0);
    check(in_ready, "R11 in_ready in reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R11 out_valid after reset", {63'd0, out_valid}, '0);

    // R2 zeros, subnormals, small and ordinary values
    send(64'h0000_0000_0000_0000, 32'd0, F_NONE, "R2 +0");
    send(64'h8000_0000_0000_0000, 32'd0, F_NONE, "R2 -0");
    send(64'h0000_0000_0000_0001, 32'd0, F_INX, "R2 +subnormal");
    send(64'h8000_0000_0000_0001, 32'd0, F_INX, "R2 -subnormal");
    send(64'h3FE0_0000_0000_0000, 32'd0, F_INX, "R2 +0.5");
    send(64'hBFE0_0000_0000_0000, 32'd0, F_INX, "R2 -0.5");
    send(64'h3FF0_0000_0000_0000, 32'd1, F_NONE, "R2 +1");
    send(64'hBFF0_0000_0000_0000, 32'hFFFF_FFFF, F_NONE, "R2 -1");
    send(64'h4004_0000_0000_0000, 32'd2, F_INX, "R2 +2.5");
    send(64'hC004_0000_0000_0000, 32'hFFFF_FFFE, F_INX, "R2 -2.5");
    // R3 exact range ends
    send(64'h41DF_FFFF_FFC0_0000, NMAX, F_NONE, "R3 Nmax exact");
    send(64'hC1E0_0000_0000_0000, NMIN, F_NONE, "R3 Nmin exact");
    // R4 half a unit beyond the ends
    send(64'h41DF_FFFF_FFE0_0000, NMAX, F_INX, "R4 Nmax+0.5");
    send(64'hC1E0_0000_0010_0000, NMIN, F_INX, "R4 Nmin-0.5");
    // R5 positive overflow
    send(64'h41E0_0000_0000_0000, NMAX, F_INV, "R5 2^31");
    send(64'h7FE0_0000_0000_0000, NMAX, F_INV, "R5 huge");
    send(64'h7FF0_0000_0000_0000, NMAX, F_INV, "R5 +inf");
    // R6 negative overflow
    send(64'hC1E0_0000_0020_0000, NMIN, F_INV, "R6 Nmin-1");
    send(64'hFFE0_0000_0000_0000, NMIN, F_INV, "R6 -huge");
    send(64'hFFF0_0000_0000_0000, NMIN, F_INV, "R6 -inf");
    // R7 quiet NaNs, R8 signaling NaNs
    send(64'h7FF8_0000_0000_0000, NMIN, F_INV, "R7 +qnan");
    send(64'hFFF8_0000_0000_0001, NMIN, F_INV, "R7 -qnan");
    send(64'h7FF0_0000_0000_0001, NMIN, F_SNAN, "R8 +snan");
    send(64'hFFF4_0000_0000_0000, NMIN, F_SNAN, "R8 -snan");

    // R9 and R2/R4/R5/R6 sweep over the exponent range against a real model
    for (int k = 0; k < 300; k++) begin
      logic [63:0] d;
      d = {$urandom(), $urandom()};
      d[62:52] = 11'(1000 + (k % 64));
      send_model(d, "R9 sweep");
    end

    // R10 back-pressure: result must stay put and input must be refused
    while (sb_q.size() != 0) @(negedge clk);
    hold_low = 1'b1;
    repeat (2) @(negedge clk);
    send(64'h4059_0000_0000_0000, 32'd100, F_NONE, "R10 held item");
    begin
      logic [63:0] first;
      first = out_data;
      check(out_valid, "R10 valid next cycle", {63'd0, out_valid}, 64'd1);
      repeat (3) @(negedge clk);
      check(out_data == first, "R10 stable under stall", out_data, first);
      check(!in_ready, "R10 in_ready low under stall", {63'd0, in_ready}, '0);
    end
    hold_low = 1'b0;
    send(64'hC059_0000_0000_0000, 32'hFFFF_FF9C, F_NONE, "R10 next in order");

    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule